// File: doc/BRIEF.md
# Serial Converter Digital Interface Model

This block reproduces, cycle by cycle on a fast system clock, the digital face of a 12-bit successive-approximation converter. A falling edge on the convert-start input freezes the sample and starts a timed conversion, and a busy flag marks the conversion. When the timer runs out, the word on the parallel sample input is taken as the result. An external serial clock then shifts that result out in a 16-bit frame on a data line that the block can release.

Conversion length, wake-up length and the final data hold are parameters counted in system clock cycles. Both asynchronous inputs pass through two-flop synchronisers before their edges are detected. If convert-start is still low when a conversion ends, the block drops into power-down. A rising edge on convert-start then starts the wake-up timer. A falling edge that arrives during wake-up raises busy at once, but the conversion itself waits until wake-up has finished.

Top module: `sar_link`

## Requirements
- R1: From the awake idle state, a falling edge on conv_start_i starts a conversion. busy_o rises on the third system clock edge after the input change, counting two synchroniser stages and one edge-detect register.
- R2: An awake conversion keeps busy_o high for exactly CONV_CYC system clock cycles, then busy_o returns low.
- R3: A falling edge on conv_start_i while busy_o is high does not restart or lengthen the conversion. A rising edge during the conversion only selects the state that follows it.
- R4: If the synchronised conv_start_i is low when a conversion ends, the block enters power-down. The next rising edge starts a wake-up of WAKE_CYC cycles. A falling edge that is detected G cycles after that rising edge, with G < WAKE_CYC, raises busy_o at once. busy_o then stays high for WAKE_CYC - G + CONV_CYC cycles.
- R5: If the falling edge comes after wake-up has finished, the conversion is an ordinary awake one of CONV_CYC cycles.
- R6: The result register takes sample_i as it stands in the last cycle of the conversion. Earlier values of sample_i have no effect.
- R7: At the end of a conversion with the serial port idle, sdata_oe_o rises and the frame is presented. The frame is 16 bits: 4 zero bits, then the 12 result bits, MSB first, in straight binary (the bit value equals the sample bit). Before any serial clock edge, frame bit 15 (a zero) is already driven. Each synchronised falling edge of sclk_i advances one bit, so after falling edge k (k = 1..15) the line carries frame bit 15-k.
- R8: After the 16th falling edge, the LSB stays on sdata_o with sdata_oe_o high for HOLD_CYC cycles. Then sdata_oe_o goes low and sdata_o reads 0.
- R9: Once the first falling edge of a frame has been seen, a conversion that completes during the rest of that frame, including its hold, leaves the frame's data unchanged and does not start a new frame.
- R10: Falling edges of sclk_i while sdata_oe_o is low have no effect. The next frame still starts at bit 15.
- R11: During and after reset, busy_o, sdata_oe_o and sdata_o are 0 and the block is awake and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_start_i | input | 1 | Convert-start strobe, asynchronous; falling edge starts, rising edge wakes |
| sclk_i | input | 1 | External serial clock, asynchronous; data advances on falling edges |
| sample_i | input | DATA_W | Parallel sample word taken at end of conversion |
| busy_o | output | 1 | High while a conversion is pending or running |
| sdata_o | output | 1 | Serial data, meaningful when sdata_oe_o is high |
| sdata_oe_o | output | 1 | Drive enable for the serial data line (low means released) |

## Verification
The hardest situation to reach is a conversion that completes while a frame is half shifted out. The serial clock and convert-start must overlap in time, and the new result must be visible only in the result register and never on the line. The bench shifts out part of a frame, runs a full conversion with a new sample word while the serial clock is paused, and then finishes the frame and expects the old word. The wake-up path is also hard to reach. To get there, the strobe must be left low through a conversion end, and the bench then times a rising and a falling edge a chosen number of cycles apart and checks that the busy length shrinks by exactly that gap.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;
  typedef enum logic [1:0] {CS_IDLE, CS_CONV, CS_DOWN, CS_WAKE} conv_st_e;
  typedef enum logic [1:0] {TX_OFF, TX_SHIFT, TX_HOLD} tx_st_e;
endpackage

// File: rtl/sar_link_sync.sv
module sar_link_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl import sar_link_pkg::*; #(
  parameter int CONV_CYC = 800,
  parameter int WAKE_CYC = 600
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cnv_lvl_i,
  input  logic     cnv_rise_i,
  input  logic     cnv_fall_i,
  output logic     busy_o,
  output logic     eoc_o,
  output conv_st_e st_o
);
  localparam int MAXC  = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  conv_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign eoc_o  = (st_q == CS_CONV) && (cnt_q == '0);
  assign busy_o = (st_q == CS_CONV) || ((st_q == CS_WAKE) && pend_q);
  assign st_o   = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        CS_IDLE: if (cnv_fall_i) begin
          st_q  <= CS_CONV;
          cnt_q <= CNT_W'(CONV_CYC - 1);
        end
        CS_CONV: begin
          if (cnt_q == '0) st_q <= cnv_lvl_i ? CS_IDLE : CS_DOWN;
          else             cnt_q <= cnt_q - 1'b1;
        end
        CS_DOWN: if (cnv_rise_i) begin
          st_q   <= CS_WAKE;
          cnt_q  <= CNT_W'(WAKE_CYC - 1);
          pend_q <= 1'b0;
        end
        CS_WAKE: begin
          if (cnt_q == '0) begin
            pend_q <= 1'b0;
            if (pend_q || cnv_fall_i) begin
              st_q  <= CS_CONV;
              cnt_q <= CNT_W'(CONV_CYC - 1);
            end else begin
              st_q <= CS_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnv_fall_i) pend_q <= 1'b1;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_link_tx.sv
module sar_link_tx import sar_link_pkg::*; #(
  parameter int DATA_W   = 12,
  parameter int LEAD_W   = 4,
  parameter int HOLD_CYC = 4,
  localparam int FRAME_W = DATA_W + LEAD_W,
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              sclk_fall_i,
  output logic              sdata_o,
  output logic              oe_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int HCNT_W = $clog2(HOLD_CYC + 1);

  tx_st_e            st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [DATA_W-1:0] shadow_q;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]  pos;

  assign frame = {{LEAD_W{1'b0}}, shadow_q};
  assign pos   = IDX_W'(FRAME_W - 1) - idx_q;
  assign oe_o  = (st_q != TX_OFF);
  assign idx_o = idx_q;

  always_comb begin
    unique case (st_q)
      TX_SHIFT: sdata_o = frame[pos];
      TX_HOLD:  sdata_o = frame[0];
      default:  sdata_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= TX_OFF;
      idx_q    <= '0;
      hcnt_q   <= '0;
      shadow_q <= '0;
    end else begin
      unique case (st_q)
        TX_OFF: if (eoc_i) begin
          st_q  <= TX_SHIFT;
          idx_q <= '0;
        end
        TX_SHIFT: if (sclk_fall_i) begin
          // frame contents freeze at the first edge
          if (idx_q == '0) shadow_q <= result_i;
          if (idx_q == IDX_W'(FRAME_W - 1)) begin
            st_q   <= TX_HOLD;
            hcnt_q <= HCNT_W'(HOLD_CYC - 1);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        TX_HOLD: begin
          if (hcnt_q == '0) st_q <= TX_OFF;
          else              hcnt_q <= hcnt_q - 1'b1;
        end
        default: st_q <= TX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sar_link.sv
module sar_link import sar_link_pkg::*; #(
  parameter int DATA_W      = 12,
  parameter int LEAD_W      = 4,
  parameter int CONV_CYC    = 800,
  parameter int WAKE_CYC    = 600,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic cnv_lvl, cnv_prev, cnv_rise, cnv_fall;
  logic sclk_lvl, sclk_prev, sclk_fall;
  logic eoc;
  conv_st_e conv_st;
  logic [DATA_W-1:0] result_q;
  logic [IDX_W-1:0]  tx_idx;

  sar_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cnv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(conv_start_i),
    .lvl_o(cnv_lvl), .prev_o(cnv_prev)
  );

  sar_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .lvl_o(sclk_lvl), .prev_o(sclk_prev)
  );

  assign cnv_rise  =  cnv_lvl  & ~cnv_prev;
  assign cnv_fall  = ~cnv_lvl  &  cnv_prev;
  assign sclk_fall = ~sclk_lvl &  sclk_prev;

  sar_link_ctrl #(.CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cnv_lvl_i(cnv_lvl), .cnv_rise_i(cnv_rise), .cnv_fall_i(cnv_fall),
    .busy_o(busy_o), .eoc_o(eoc), .st_o(conv_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  result_q <= '0;
    else if (eoc) result_q <= sample_i;
  end

  sar_link_tx #(.DATA_W(DATA_W), .LEAD_W(LEAD_W), .HOLD_CYC(HOLD_CYC)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .eoc_i(eoc), .result_i(result_q),
    .sclk_fall_i(sclk_fall), .sdata_o(sdata_o), .oe_o(sdata_oe_o), .idx_o(tx_idx)
  );
endmodule

// File: rtl/sar_link_chk.sv
module sar_link_chk import sar_link_pkg::*; #(
  parameter int CONV_CYC = 800,
  parameter int LEAD_W   = 4,
  parameter int IDX_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnv_fall,
  input logic             cnv_lvl,
  input logic             sclk_fall,
  input logic             eoc,
  input conv_st_e         conv_st,
  input logic             busy_o,
  input logic             sdata_o,
  input logic             sdata_oe_o,
  input logic [IDX_W-1:0] tx_idx
);
  int conv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 conv_run <= 0;
    else if (conv_st != CS_CONV) conv_run <= 0;
    else                         conv_run <= conv_run + 1;
  end

  a_r1_start_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_st == CS_IDLE && cnv_fall) |=> busy_o);

  // R3: a restart would reset the counter and break this length
  a_r2_conv_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc |-> (conv_run == CONV_CYC - 1));

  a_r4_enter_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc && !cnv_lvl) |=> (conv_st == CS_DOWN && !busy_o));

  a_r7_lead_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && int'(tx_idx) < LEAD_W) |-> !sdata_o);

  a_r7_data_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && $past(sdata_oe_o) && !$past(sclk_fall)) |-> $stable(sdata_o));

  a_r11_released_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);
endmodule

bind sar_link sar_link_chk #(.CONV_CYC(CONV_CYC), .LEAD_W(LEAD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnv_fall(cnv_fall), .cnv_lvl(cnv_lvl),
  .sclk_fall(sclk_fall), .eoc(eoc), .conv_st(conv_st), .busy_o(busy_o),
  .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .tx_idx(tx_idx)
);

// File: tb/sar_link_tb.sv
module sar_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 40;
  localparam int WAKE = 30;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] sample = '0;
  logic        busy, sdata, oe;

  int n_chk = 0;
  int n_err = 0;
  bit pdn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_link #(.CONV_CYC(CONV), .WAKE_CYC(WAKE), .HOLD_CYC(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .conv_start_i(conv), .sclk_i(sclk),
    .sample_i(sample), .busy_o(busy), .sdata_o(sdata), .sdata_oe_o(oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] frame_of(input logic [11:0] s);
    return {4'b0000, s};
  endfunction

  // falls conv at current negedge, measures busy run length in cycles
  task automatic run_conv(input int rise_at, input int refall_at, input int chg_at,
                          input logic [11:0] chg_val, output int len, output int first);
    bit seen = 1'b0;
    len = 0; first = -1;
    conv = 1'b0;
    for (int t = 1; t < 4000; t++) begin
      @(negedge clk);
      if (busy) begin
        if (!seen) first = t;
        seen = 1'b1; len++;
      end else if (seen) break;
      if (t == rise_at)   conv = 1'b1;
      if (t == refall_at) conv = 1'b0;
      if (t == chg_at)    sample = chg_val;
    end
  endtask

  task automatic rd_bit(input int k, input logic [15:0] f, input string req);
    int hi = 4 + int'($urandom % 5);
    int lo = 4 + int'($urandom % 5);
    sclk = 1'b1; tick(hi);
    sclk = 1'b0;
    if (k < 16) begin
      tick(lo);
      chk({req, " oe mid-frame"}, int'(oe), 1);
      chk({req, " frame bit"}, int'(sdata), int'(f[15-k]));
    end else begin
      tick(3 + HOLD - 1);
      chk("R8 oe in hold", int'(oe), 1);
      chk("R8 lsb in hold", int'(sdata), int'(f[0]));
      tick(1);
      chk("R8 oe released", int'(oe), 0);
      chk("R8 data low released", int'(sdata), 0);
    end
  endtask

  task automatic rd_frame(input logic [15:0] f, input int from_k, input int to_k, input string req);
    if (from_k == 1) begin
      chk({req, " oe before edges"}, int'(oe), 1);
      chk({req, " first zero"}, int'(sdata), 0);
    end
    for (int k = from_k; k <= to_k; k++) rd_bit(k, f, req);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int len, first;
    int unsigned seed_init;
    logic [11:0] v;
    seed_init = $urandom(32'd7731);

    tick(3);
    chk("R11 busy in reset", int'(busy), 0);
    chk("R11 oe in reset", int'(oe), 0);
    rst_ni = 1'b1;
    tick(3);
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 oe after reset", int'(oe), 0);
    chk("R11 data after reset", int'(sdata), 0);

    // R1 R2 R6: sample changes mid conversion, value at end is taken
    sample = 12'hA5C;
    run_conv(10, 0, 20, 12'h3B7, len, first);
    chk("R1 busy latency", first, 3);
    chk("R2 busy length", len, CONV);
    rd_frame(frame_of(12'h3B7), 1, 16, "R6 R7");

    // R10: serial edges with line released
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; tick(5); sclk = 1'b0; tick(5);
      chk("R10 oe stays low", int'(oe), 0);
    end
    sample = 12'h801;
    run_conv(5, 0, 0, 12'h0, len, first);
    chk("R2 busy length", len, CONV);
    rd_frame(frame_of(12'h801), 1, 16, "R10");

    // R3: re-trigger during busy ignored; strobe low at end -> power-down
    sample = 12'h0FF;
    run_conv(5, 9, 0, 12'h0, len, first);
    chk("R3 no restart length", len, CONV);
    rd_frame(frame_of(12'h0FF), 1, 16, "R7");

    // R4: wake then convert with gap 3
    sample = 12'h555;
    conv = 1'b1; tick(3);
    run_conv(0, 0, 0, 12'h0, len, first);
    chk("R4 busy latency", first, 3);
    chk("R4 wake+conv length", len, WAKE - 3 + CONV);
    rd_frame(frame_of(12'h555), 1, 16, "R4");

    // R5: wide pulse, wake finished before fall
    sample = 12'hC3A;
    conv = 1'b1; tick(WAKE + 8);
    run_conv(6, 0, 0, 12'h0, len, first);
    chk("R5 awake length", len, CONV);
    rd_frame(frame_of(12'hC3A), 1, 16, "R5");

    // R9: conversion completes mid readout
    sample = 12'h9C3;
    run_conv(5, 0, 0, 12'h0, len, first);
    rd_frame(frame_of(12'h9C3), 1, 6, "R9");
    sample = 12'h124;
    run_conv(5, 0, 0, 12'h0, len, first);
    chk("R2 busy length", len, CONV);
    rd_frame(frame_of(12'h9C3), 7, 16, "R9");
    tick(4);
    chk("R9 no new frame", int'(oe), 0);

    pdn = 1'b0;
    for (int it = 0; it < 10; it++) begin
      int rise_at;
      int gap;
      bit use_wake;
      v = 12'($urandom);
      use_wake = pdn && ($urandom % 2 == 1);
      if (pdn && !use_wake) begin
        conv = 1'b1; tick(WAKE + 6);
      end
      sample = v;
      rise_at = ($urandom % 2 == 1) ? 0 : 4 + int'($urandom % (CONV - 7));
      if (use_wake) begin
        gap = 2 + int'($urandom % (WAKE - 6));
        conv = 1'b1; tick(gap);
        run_conv(rise_at, 0, 0, 12'h0, len, first);
        chk("R4 random wake length", len, WAKE - gap + CONV);
      end else begin
        run_conv(rise_at, 0, 0, 12'h0, len, first);
        chk("R2 random length", len, CONV);
      end
      pdn = (rise_at == 0);
      rd_frame(frame_of(v), 1, 16, "R7 random");
    end

    finish_up();
  end
endmodule